// File: doc/BRIEF.md
# Serial Freeze Control for Gated Clock Outputs

This block lets a controller stop and restart each of twelve clock outputs through a two-wire serial link. The link has a data line and its own clock. A frame opens with a zero start bit and carries twelve enable bits. Once a frame is complete, its enables replace the stored set together. An enable of 0 parks its output low. An enable of 1 lets the output follow its source clock again.

Every output has its own source clock, and no two sources need to be related. Each stored enable is synchronised into the domain of its output's source clock. The new value is applied only while that source clock is low. Because of this, an output always stops after a complete high phase and always restarts with a complete high phase, and no shortened pulse appears.

Between frames the serial data line idles at 1. The receiver skips these idle bits until it sees a zero, which opens the next frame.

Top module: `clk_freeze_ctrl`

## Requirements
- R1: While reset is asserted and after it is released, all twelve stored enables are 1. Every output follows its source clock, and the receiver waits for a start bit.
- R2: The serial data line is sampled on each rising edge of the serial clock. A frame is one 0 start bit followed by twelve enable bits. The k-th enable bit after the start bit (k = 0..11) controls output k: 0 freezes it and 1 lets it run.
- R3: The stored enables keep their old values until a whole frame has been received. This holds however many bits of a frame are in, up to and including the twelfth. The new set takes effect at the next rising serial clock edge after the twelfth bit.
- R4: The bit sampled on that commit edge is checked as a possible start bit. If it is 0, it opens the next frame at once.
- R5: While the receiver waits for a frame, 1 bits on the data line change nothing.
- R6: A frozen output falls only at its source's normal falling edge and then stays low.
- R7: A restarted output rises only at its source's normal rising edge. No output high or low phase is ever shorter than the source's half period, and an output is never high while its source is low.
- R8: Each enable passes through a two-stage synchroniser clocked by its output's source clock, and it is applied at a source falling edge. A committed change is therefore visible within four source periods.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ser_clk_i | input | 1 | Serial link clock; data is sampled on its rising edge |
| ser_data_i | input | 1 | Serial link data; idles at 1 |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously in every domain |
| src_clk_i | input | 12 | Source clocks to be gated, one per output |
| gclk_o | output | 12 | Gated clock outputs |

## Verification
Each output runs from a source clock with its own period, and no source is related to the serial clock. The bench sends the following frames:
- A frame with a single 0 at bit 0. This shows whether the bit order is right or reversed.
- A frame stopped partway through, and a frame stopped right after its twelfth bit. These show a commit made too early apart from the correct commit edge.
- Two frames sent back to back, where the second frame's start bit falls on the first frame's commit edge.
- Long runs of idle 1 bits. These would be taken in if the receiver shifted them as data.
- A series of random enable patterns with random idle gaps.

Throughout the run, the width of every high and low phase of every output is measured. A runt pulse produced while an output stops or restarts shows up in these widths.

// File: rtl/frz_pkg.sv
`timescale 1ns/1ps
package frz_pkg;
  parameter int unsigned FRZ_OUTS = 12;

  typedef enum logic [1:0] {
    RX_WAIT  = 2'd0,
    RX_SHIFT = 2'd1,
    RX_APPLY = 2'd2
  } rx_state_e;
endpackage

// File: rtl/frz_rst_sync.sv
`timescale 1ns/1ps
module frz_rst_sync (
  input  logic clk_i,
  input  logic arst_ni,
  output logic rst_no
);
  logic stage_q;

  always_ff @(posedge clk_i or negedge arst_ni) begin
    if (!arst_ni) begin
      stage_q <= 1'b0;
      rst_no  <= 1'b0;
    end else begin
      stage_q <= 1'b1;
      rst_no  <= stage_q;
    end
  end
endmodule

// File: rtl/frz_rx.sv
`timescale 1ns/1ps
module frz_rx #(
  parameter int unsigned N_OUT = frz_pkg::FRZ_OUTS
) (
  input  logic             ser_clk_i,
  input  logic             arst_ni,
  input  logic             ser_data_i,
  output logic [N_OUT-1:0] en_o
);
  import frz_pkg::*;

  localparam int unsigned CW   = (N_OUT > 1) ? $clog2(N_OUT) : 1;
  localparam logic [CW-1:0] LAST = CW'(N_OUT - 1);

  logic             rst_s;
  rx_state_e        state_q, state_d;
  logic [CW-1:0]    cnt_q, cnt_d;
  logic [N_OUT-1:0] sr_q, sr_d;
  logic [N_OUT-1:0] en_q, en_d;
  logic             sr_we, en_we, cnt_we;

  frz_rst_sync u_rst (.clk_i(ser_clk_i), .arst_ni(arst_ni), .rst_no(rst_s));

  // next-state logic
  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    sr_d    = {ser_data_i, sr_q[N_OUT-1:1]};
    en_d    = sr_q;
    sr_we   = 1'b0;
    en_we   = 1'b0;
    cnt_we  = 1'b0;
    unique case (state_q)
      RX_WAIT: begin
        if (!ser_data_i) begin
          state_d = RX_SHIFT;
          cnt_d   = '0;
          cnt_we  = 1'b1;
        end
      end
      RX_SHIFT: begin
        sr_we = 1'b1;
        if (cnt_q == LAST) begin
          state_d = RX_APPLY;
        end else begin
          cnt_d  = cnt_q + 1'b1;
          cnt_we = 1'b1;
        end
      end
      RX_APPLY: begin
        en_we = 1'b1;
        if (!ser_data_i) begin
          state_d = RX_SHIFT;
          cnt_d   = '0;
          cnt_we  = 1'b1;
        end else begin
          state_d = RX_WAIT;
        end
      end
      default: state_d = RX_WAIT;
    endcase
  end

  // registers
  always_ff @(posedge ser_clk_i or negedge rst_s) begin
    if (!rst_s) begin
      state_q <= RX_WAIT;
      cnt_q   <= '0;
      sr_q    <= '1;
      en_q    <= '1;
    end else begin
      state_q <= state_d;
      if (cnt_we) cnt_q <= cnt_d;
      if (sr_we)  sr_q  <= sr_d;
      if (en_we)  en_q  <= en_d;
    end
  end

  assign en_o = en_q;

  // R3: enables move only on the commit edge
  a_r3_hold_until_commit: assert property (@(posedge ser_clk_i) disable iff (!rst_s)
    (state_q != RX_APPLY) |=> $stable(en_q));

  // R4: a zero on the commit edge opens the next frame
  a_r4_chain_start: assert property (@(posedge ser_clk_i) disable iff (!rst_s)
    (state_q == RX_APPLY && !ser_data_i) |=> (state_q == RX_SHIFT && cnt_q == '0));

  // R5: idle ones keep the receiver waiting
  a_r5_idle_ones: assert property (@(posedge ser_clk_i) disable iff (!rst_s)
    (state_q == RX_WAIT && ser_data_i) |=> (state_q == RX_WAIT && $stable(en_q)));

  // R2: a frame never ends directly from the waiting state
  a_r2_no_skip: assert property (@(posedge ser_clk_i) disable iff (!rst_s)
    (state_q == RX_WAIT) |=> (state_q != RX_APPLY));
endmodule

// File: rtl/frz_gate.sv
`timescale 1ns/1ps
module frz_gate (
  input  logic clk_i,
  input  logic arst_ni,
  input  logic en_i,
  output logic gclk_o
);
  logic rst_s;
  logic en_s1_q, en_s2_q;
  logic en_lat_q;

  frz_rst_sync u_rst (.clk_i(clk_i), .arst_ni(arst_ni), .rst_no(rst_s));

  // two-stage synchroniser in the source clock domain
  always_ff @(posedge clk_i or negedge rst_s) begin
    if (!rst_s) begin
      en_s1_q <= 1'b1;
      en_s2_q <= 1'b1;
    end else begin
      en_s1_q <= en_i;
      en_s2_q <= en_s1_q;
    end
  end

  // enable changes only at a falling edge, while the source is low
  always_ff @(negedge clk_i or negedge rst_s) begin
    if (!rst_s) en_lat_q <= 1'b1;
    else        en_lat_q <= en_s2_q;
  end

  assign gclk_o = clk_i & en_lat_q;

  // R7: output high only inside a source high phase
  always_comb begin
    if (rst_s) begin
      a_r7_high_within_src: assert (!(gclk_o && !clk_i));
    end
  end
endmodule

// File: rtl/clk_freeze_ctrl.sv
`timescale 1ns/1ps
module clk_freeze_ctrl #(
  parameter int unsigned N_OUT = frz_pkg::FRZ_OUTS
) (
  input  logic             ser_clk_i,
  input  logic             ser_data_i,
  input  logic             rst_ni,
  input  logic [N_OUT-1:0] src_clk_i,
  output logic [N_OUT-1:0] gclk_o
);
  logic [N_OUT-1:0] en;

  frz_rx #(.N_OUT(N_OUT)) u_rx (
    .ser_clk_i (ser_clk_i),
    .arst_ni   (rst_ni),
    .ser_data_i(ser_data_i),
    .en_o      (en)
  );

  for (genvar g = 0; g < N_OUT; g++) begin : g_out
    frz_gate u_gate (
      .clk_i  (src_clk_i[g]),
      .arst_ni(rst_ni),
      .en_i   (en[g]),
      .gclk_o (gclk_o[g])
    );
  end
endmodule

// File: tb/sim_clk_freeze_ctrl.sv
`timescale 1ns/1ps
module sim_clk_freeze_ctrl;
  localparam int N = 12;

  logic          clk;
  logic          ser_clk, ser_data, rst_n;
  logic [N-1:0]  src_clk;
  logic [N-1:0]  gclk;
  logic          meas_on;
  int            checks, errors, cyc;
  int            rises [N];
  int            runts [N];
  logic [N-1:0]  exp_q [$];
  logic [N-1:0]  cur;

  clk_freeze_ctrl u0 (
    .ser_clk_i (ser_clk),
    .ser_data_i(ser_data),
    .rst_ni    (rst_n),
    .src_clk_i (src_clk),
    .gclk_o    (gclk)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // source clocks: half period 3+i ns, plus phase-width monitor
  for (genvar i = 0; i < N; i++) begin : g_src
    realtime t_r, t_f;
    bit      seen_r, seen_f;
    initial begin
      src_clk[i] = 1'b0;
      rises[i]   = 0;
      runts[i]   = 0;
      seen_r     = 0;
      seen_f     = 0;
    end
    always #(3 + i) src_clk[i] = ~src_clk[i];
    always @(posedge gclk[i]) begin
      if (meas_on) begin
        if (seen_f && ($realtime - t_f) < (3.0 + i - 0.01)) runts[i] = runts[i] + 1;
        t_r = $realtime; seen_r = 1; rises[i] = rises[i] + 1;
      end else begin
        seen_r = 0; seen_f = 0;
      end
    end
    always @(negedge gclk[i]) begin
      if (meas_on) begin
        if (seen_r && ($realtime - t_r) < (3.0 + i - 0.01)) runts[i] = runts[i] + 1;
        t_f = $realtime; seen_f = 1;
      end else begin
        seen_r = 0; seen_f = 0;
      end
    end
  end

  always @(posedge clk) begin
    cyc = cyc + 1;
    if (cyc == 100000) begin
      errors = errors + 1;
      $display("FAIL watchdog: run hung, actual cycles %0d expected fewer", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic ser_bit(input logic b);
    ser_data = b;
    #2 ser_clk = 1'b1;
    #2 ser_clk = 1'b0;
  endtask

  // driver: start bit plus twelve enables, bit 0 first; expected pushed
  task automatic drive_frame(input logic [N-1:0] pat);
    ser_bit(1'b0);
    for (int k = 0; k < N; k++) ser_bit(pat[k]);
    exp_q.push_back(pat);
  endtask

  // observe which outputs run; frozen ones must have no rise and sit low
  task automatic observe(output logic [N-1:0] obs);
    int base [N];
    #150;
    for (int i = 0; i < N; i++) base[i] = rises[i];
    #120;
    for (int i = 0; i < N; i++) begin
      if (rises[i] != base[i]) obs[i] = 1'b1;
      else                     obs[i] = gclk[i];
    end
  endtask

  task automatic compare(input logic [N-1:0] exp, input string tag);
    logic [N-1:0] obs;
    observe(obs);
    checks = checks + 1;
    if (obs !== exp) begin
      errors = errors + 1;
      $display("FAIL %s: running outputs actual %b expected %b", tag, obs, exp);
    end
  endtask

  // monitor: pop the next expected set and compare
  task automatic monitor_check(input string tag);
    logic [N-1:0] e;
    e = exp_q.pop_front();
    cur = e;
    compare(e, tag);
  endtask

  task automatic do_reset();
    meas_on = 1'b0;
    rst_n = 1'b0;
    repeat (3) ser_bit(1'b1);
    #60;
    rst_n = 1'b1;
    repeat (3) ser_bit(1'b1);
    #100;
    meas_on = 1'b1;
    cur = '1;
  endtask

  initial begin
    int total_runts;
    checks = 0; errors = 0; cyc = 0;
    ser_clk = 1'b0; ser_data = 1'b1; rst_n = 1'b0; meas_on = 1'b0;

    do_reset();
    compare('1, "R1 all outputs run after reset");

    // bit order: single zero in bit 0 freezes output 0 only
    drive_frame(12'hFFE);
    compare(cur, "R3 twelve bits in, no commit yet");
    ser_bit(1'b1);
    monitor_check("R2 bit 0 maps to output 0");

    // partial frame then completion
    ser_bit(1'b0);
    for (int k = 0; k < 6; k++) ser_bit(1'b0);
    compare(cur, "R3 partial frame changes nothing");
    for (int k = 0; k < 6; k++) ser_bit(1'b1);
    exp_q.push_back(12'hFC0);
    compare(cur, "R3 full frame before commit edge");
    ser_bit(1'b1);
    monitor_check("R2 low half frozen");
    compare(cur, "R6 frozen outputs held low");

    // back-to-back frames: start bit on commit edge
    drive_frame(12'h5A5);
    drive_frame(12'h0F3);
    begin
      logic [N-1:0] first;
      first = exp_q.pop_front();
      compare(first, "R4 first frame committed by chained start bit");
    end
    ser_bit(1'b1);
    monitor_check("R4 chained frame applied");

    // long idle run
    repeat (40) ser_bit(1'b1);
    compare(cur, "R5 idle ones ignored");

    // random patterns with random idle gaps
    for (int n = 0; n < 8; n++) begin
      logic [N-1:0] p;
      p = N'($urandom);
      drive_frame(p);
      repeat (1 + ($urandom % 4)) ser_bit(1'b1);
      monitor_check("R8 random frame visible after sync");
    end

    // all frozen, then all released
    drive_frame('0);
    ser_bit(1'b1);
    monitor_check("R6 all outputs frozen");
    drive_frame('1);
    ser_bit(1'b1);
    monitor_check("R7 all outputs restarted");

    total_runts = 0;
    for (int i = 0; i < N; i++) total_runts = total_runts + runts[i];
    checks = checks + 1;
    if (total_runts != 0) begin
      errors = errors + 1;
      $display("FAIL R7 short phases: actual %0d expected 0", total_runts);
    end

    // reset during frozen state restores all
    drive_frame(12'h00F);
    ser_bit(1'b1);
    monitor_check("R2 pattern before reset");
    do_reset();
    compare('1, "R1 reset releases every output");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule